// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block is one DMA channel that copies data from a source address range to a destination address range on its own. Software programs the channel through a small register port. It sets a source address, a destination address, a byte count and a mode word, then sets the enable bit. From then on the channel makes its own requests. Each transfer reads one item from the source and then writes that item to the destination, over a simple bus master port that waits on a ready handshake.

Source and destination each have their own access size, 1, 2 or 4 bytes. Each also has its own address policy. A fixed address suits a peripheral data port. An advancing address suits a buffer in memory, and it moves on by the size of the access just made. The byte count goes down by the destination size on each write. When the count reaches zero the channel raises a done flag and disables itself. A reserved size code raises an error flag instead. Either flag blocks any new transfer until software clears it. Writing the self-clearing abort bit stops the channel cleanly: a bus access already in progress completes, and then the channel goes idle.

Top module: `dma_xfer_engine`

## Requirements
- R1: While the enable bit (mode bit 30) is 0, the channel makes no bus access, and the address and count registers keep the values software wrote.
- R2: Each transfer is one read of the source address followed by one write to the destination address. The write carries the data the read returned. While bus_rdy is low, bus_req, bus_we and bus_addr hold steady.
- R3: Size codes are 00 = 4 bytes, 01 = 1 byte and 10 = 2 bytes. The source code sits in mode bits 1:0 and the destination code in mode bits 9:8. bus_size carries the code of the side being accessed.
- R4: A side whose advance bit is 1 (mode bit 4 for the source, bit 12 for the destination) has its address raised by its own size in bytes after each completed transfer.
- R5: A side whose advance bit is 0 keeps its address unchanged across transfers.
- R6: Each completed write lowers the byte count by the destination size, and the count stops at zero rather than wrapping. When it reaches zero, the done flag (status bit 0) is set and the enable bit is cleared.
- R7: Enabling the channel with a byte count of zero sets the done flag and clears the enable bit, with no bus access.
- R8: Enabling the channel with size code 11 on either side sets the error flag (status bit 1) and clears the enable bit, with no bus access.
- R9: The done and error flags are cleared by writing 1 to them. While either flag is set, no transfer starts even with the enable bit at 1.
- R10: Writing 1 to mode bit 31 clears the enable bit. An access in progress completes, and then no further access is made and neither the addresses nor the count change. Bit 31 always reads back as 0.
- R11: After reset every register reads as zero and bus_req is low.
- R12: Mode bits other than 30, 12, 9:8, 4 and 1:0 read back as zero. Register indices are 0 = mode, 1 = source, 2 = destination, 3 = count and 4 = status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | ADDR_W | Access address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, taken when bus_rdy is high |
| bus_rdy | input | 1 | Completes the current access |

## Verification
A register write takes effect at the clock edge where reg_we is high. The channel reacts at the following edge: it enters its read access, or it sets a flag and clears the enable bit. Each access then lasts as many cycles as bus_rdy stays low, plus one, so a transfer with no wait states takes two cycles. Because that timing is data-dependent, the bench stimulus never relies on fixed delays. It drives inputs shortly after the rising edge and samples on the falling edge. It polls the status register until a flag appears and only then reads the results. For actions that must have no effect, it waits a fixed number of cycles, well beyond the one-cycle reaction time, and then confirms that no access happened.

// File: rtl/dma_pkg.sv
package dma_pkg;

   localparam int REG_W = 32;

   // register indices
   localparam logic [2:0] RA_MODE = 3'd0;
   localparam logic [2:0] RA_SRC  = 3'd1;
   localparam logic [2:0] RA_DST  = 3'd2;
   localparam logic [2:0] RA_CNT  = 3'd3;
   localparam logic [2:0] RA_STAT = 3'd4;

   // mode word bit positions
   localparam int MB_ABORT = 31;
   localparam int MB_EN    = 30;
   localparam int MB_DINC  = 12;
   localparam int MB_DSZ   = 8;
   localparam int MB_SINC  = 4;
   localparam int MB_SSZ   = 0;

   // status bit positions
   localparam int SB_DONE = 0;
   localparam int SB_ERR  = 1;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_READ  = 2'd1,
      SQ_WRITE = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic       inc;
      logic [1:0] sz;
   } side_cfg_t;

   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'b00:   return 3'd4;
         2'b01:   return 3'd1;
         2'b10:   return 3'd2;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic size_valid(input logic [1:0] code);
      return code != 2'b11;
   endfunction

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
   import dma_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_val,
   input  logic              adv,
   input  side_cfg_t         cfg,
   output logic [ADDR_W-1:0] addr
);

   localparam int STEP_W = 3;

   if (ADDR_W <= STEP_W) begin : g_bad_width
      $error("dma_addr_unit: ADDR_W too small");
   end

   logic [ADDR_W-1:0] step;
   assign step = ADDR_W'(size_bytes(cfg.sz));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (adv) begin
         if (cfg.inc) addr <= addr + step;
      end else if (ld) begin
         addr <= ld_val;
      end
   end

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
   import dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [ADDR_W-1:0] dst_addr,
   output logic              src_ld,
   output logic              dst_ld,
   output logic              abort_req,
   output logic              en,
   output side_cfg_t         src_cfg,
   output side_cfg_t         dst_cfg,
   output logic [CNT_W-1:0]  count,
   output logic              flag_done,
   output logic              flag_err,
   input  logic              ev_xfer,
   input  logic [2:0]        ev_amt,
   input  logic              ev_done,
   input  logic              ev_err,
   input  logic              ev_en_clr
);

   if (CNT_W < 3 || CNT_W > REG_W) begin : g_bad_cnt
      $error("dma_ctrl_regs: CNT_W out of range");
   end
   if (ADDR_W > REG_W) begin : g_bad_addr
      $error("dma_ctrl_regs: ADDR_W wider than register");
   end

   logic wr_mode, wr_cnt, wr_stat;
   assign wr_mode   = reg_we && (reg_addr == RA_MODE);
   assign wr_cnt    = reg_we && (reg_addr == RA_CNT);
   assign wr_stat   = reg_we && (reg_addr == RA_STAT);
   assign src_ld    = reg_we && (reg_addr == RA_SRC);
   assign dst_ld    = reg_we && (reg_addr == RA_DST);
   assign abort_req = wr_mode && reg_wdata[MB_ABORT];

   logic [CNT_W-1:0] amt;
   assign amt = CNT_W'(ev_amt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en        <= 1'b0;
         src_cfg   <= '0;
         dst_cfg   <= '0;
         count     <= '0;
         flag_done <= 1'b0;
         flag_err  <= 1'b0;
      end else begin
         if (ev_en_clr || abort_req) en <= 1'b0;
         else if (wr_mode)           en <= reg_wdata[MB_EN];

         if (wr_mode) begin
            src_cfg <= '{inc: reg_wdata[MB_SINC], sz: reg_wdata[MB_SSZ +: 2]};
            dst_cfg <= '{inc: reg_wdata[MB_DINC], sz: reg_wdata[MB_DSZ +: 2]};
         end

         if (ev_xfer)     count <= (count <= amt) ? '0 : count - amt;
         else if (wr_cnt) count <= reg_wdata[CNT_W-1:0];

         flag_done <= (flag_done & ~(wr_stat & reg_wdata[SB_DONE])) | ev_done;
         flag_err  <= (flag_err  & ~(wr_stat & reg_wdata[SB_ERR]))  | ev_err;
      end
   end

   logic [REG_W-1:0] mode_rb, cnt_rb, stat_rb;

   always_comb begin
      mode_rb                 = '0;
      mode_rb[MB_EN]          = en;
      mode_rb[MB_DINC]        = dst_cfg.inc;
      mode_rb[MB_DSZ +: 2]    = dst_cfg.sz;
      mode_rb[MB_SINC]        = src_cfg.inc;
      mode_rb[MB_SSZ +: 2]    = src_cfg.sz;
      stat_rb                 = '0;
      stat_rb[SB_DONE]        = flag_done;
      stat_rb[SB_ERR]         = flag_err;
   end

   if (CNT_W == REG_W) begin : g_cnt_full
      assign cnt_rb = count;
   end else begin : g_cnt_pad
      assign cnt_rb = {{(REG_W-CNT_W){1'b0}}, count};
   end

   always_comb begin
      case (reg_addr)
         RA_MODE: reg_rdata = mode_rb;
         RA_SRC:  reg_rdata = REG_W'(src_addr);
         RA_DST:  reg_rdata = REG_W'(dst_addr);
         RA_CNT:  reg_rdata = cnt_rb;
         RA_STAT: reg_rdata = stat_rb;
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
   import dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              flag_done,
   input  logic              flag_err,
   input  logic              abort_req,
   input  logic [CNT_W-1:0]  count,
   input  side_cfg_t         src_cfg,
   input  side_cfg_t         dst_cfg,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic              bus_rdy,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        bus_size,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              src_adv,
   output logic              dst_adv,
   output logic              ev_xfer,
   output logic [2:0]        ev_amt,
   output logic              ev_done,
   output logic              ev_err,
   output logic              ev_en_clr
);

   seq_state_e        state, nxt;
   logic              abort_pend;
   logic              abort_now;
   logic [DATA_W-1:0] hold;
   logic [2:0]        dbytes;

   assign abort_now = abort_pend | abort_req;
   assign dbytes    = size_bytes(dst_cfg.sz);
   assign bus_wdata = hold;

   always_comb begin
      nxt       = state;
      bus_req   = 1'b0;
      bus_we    = 1'b0;
      bus_addr  = src_addr;
      bus_size  = src_cfg.sz;
      src_adv   = 1'b0;
      dst_adv   = 1'b0;
      ev_xfer   = 1'b0;
      ev_amt    = dbytes;
      ev_done   = 1'b0;
      ev_err    = 1'b0;
      ev_en_clr = 1'b0;
      case (state)
         SQ_IDLE: begin
            if (en && !flag_done && !flag_err && !abort_req) begin
               if (!size_valid(src_cfg.sz) || !size_valid(dst_cfg.sz)) begin
                  ev_err    = 1'b1;
                  ev_en_clr = 1'b1;
               end else if (count == '0) begin
                  ev_done   = 1'b1;
                  ev_en_clr = 1'b1;
               end else begin
                  nxt = SQ_READ;
               end
            end
         end
         SQ_READ: begin
            bus_req = 1'b1;
            if (bus_rdy) nxt = abort_now ? SQ_IDLE : SQ_WRITE;
         end
         SQ_WRITE: begin
            bus_req  = 1'b1;
            bus_we   = 1'b1;
            bus_addr = dst_addr;
            bus_size = dst_cfg.sz;
            if (bus_rdy) begin
               if (abort_now) begin
                  nxt = SQ_IDLE;
               end else begin
                  src_adv = 1'b1;
                  dst_adv = 1'b1;
                  ev_xfer = 1'b1;
                  if (count <= CNT_W'(dbytes)) begin
                     ev_done   = 1'b1;
                     ev_en_clr = 1'b1;
                     nxt       = SQ_IDLE;
                  end else begin
                     nxt = en ? SQ_READ : SQ_IDLE;
                  end
               end
            end
         end
         default: nxt = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SQ_IDLE;
         abort_pend <= 1'b0;
         hold       <= '0;
      end else begin
         state <= nxt;
         if (state != SQ_IDLE && nxt == SQ_IDLE) abort_pend <= 1'b0;
         else if (abort_req && state != SQ_IDLE) abort_pend <= 1'b1;
         if (state == SQ_READ && bus_rdy) hold <= bus_rdata;
      end
   end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
   import dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        bus_size,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_rdy
);

   localparam int N_SIDE = 2;
   localparam int S_SRC  = 0;
   localparam int S_DST  = 1;

   if (ADDR_W < 8 || ADDR_W > REG_W) begin : g_bad_addr
      $error("dma_xfer_engine: ADDR_W must be 8..32");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("dma_xfer_engine: DATA_W must be 32");
   end

   logic              en_q, done_q, err_q, abort_req;
   side_cfg_t         cfg   [N_SIDE];
   logic              ld    [N_SIDE];
   logic              adv   [N_SIDE];
   logic [ADDR_W-1:0] addr_q[N_SIDE];
   logic [CNT_W-1:0]  count;
   logic              ev_xfer, ev_done, ev_err, ev_en_clr;
   logic [2:0]        ev_amt;

   dma_ctrl_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .src_addr  (addr_q[S_SRC]),
      .dst_addr  (addr_q[S_DST]),
      .src_ld    (ld[S_SRC]),
      .dst_ld    (ld[S_DST]),
      .abort_req (abort_req),
      .en        (en_q),
      .src_cfg   (cfg[S_SRC]),
      .dst_cfg   (cfg[S_DST]),
      .count     (count),
      .flag_done (done_q),
      .flag_err  (err_q),
      .ev_xfer   (ev_xfer),
      .ev_amt    (ev_amt),
      .ev_done   (ev_done),
      .ev_err    (ev_err),
      .ev_en_clr (ev_en_clr)
   );

   for (genvar i = 0; i < N_SIDE; i++) begin : g_side
      dma_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld     (ld[i]),
         .ld_val (reg_wdata[ADDR_W-1:0]),
         .adv    (adv[i]),
         .cfg    (cfg[i]),
         .addr   (addr_q[i])
      );
   end

   dma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_q),
      .flag_done (done_q),
      .flag_err  (err_q),
      .abort_req (abort_req),
      .count     (count),
      .src_cfg   (cfg[S_SRC]),
      .dst_cfg   (cfg[S_DST]),
      .src_addr  (addr_q[S_SRC]),
      .dst_addr  (addr_q[S_DST]),
      .bus_rdy   (bus_rdy),
      .bus_rdata (bus_rdata),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_size  (bus_size),
      .bus_wdata (bus_wdata),
      .src_adv   (adv[S_SRC]),
      .dst_adv   (adv[S_DST]),
      .ev_xfer   (ev_xfer),
      .ev_amt    (ev_amt),
      .ev_done   (ev_done),
      .ev_err    (ev_err),
      .ev_en_clr (ev_en_clr)
   );

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [2:0]        reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rdy,
   input logic              mode_en,
   input logic              flag_done,
   input logic              flag_err
);

   p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_en && !bus_req) |=> !bus_req);

   p_hold_on_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

   p_read_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> !bus_we);

   p_done_disables_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_done) |-> !mode_en);

   p_err_disables_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_err) |-> !mode_en);

   p_flag_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_req && (flag_done || flag_err)) |=> !bus_req);

   p_abort_disables_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd0 && reg_wdata[31]) |=> !mode_en);

   p_abort_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 3'd0) |-> !reg_rdata[31]);

endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_rdy   (bus_rdy),
   .mode_en   (en_q),
   .flag_done (done_q),
   .flag_err  (err_q)
);

// File: tb/tb_dma_xfer_engine.sv
module tb_dma_xfer_engine;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam logic [31:0] SCRAMBLE = 32'hC3C3_0000;

   typedef struct packed {
      logic [31:0] src;
      logic [31:0] dst;
      logic [15:0] cnt;
      logic        sinc;
      logic        dinc;
      logic [1:0]  ssz;
      logic [1:0]  dsz;
      logic [31:0] exp_src;
      logic [31:0] exp_dst;
      logic [7:0]  exp_wr;
   } vec_t;

   localparam int NV = 4;
   localparam vec_t VECS [NV] = '{
      '{32'h100, 32'h200, 16'd16, 1'b1, 1'b1, 2'b00, 2'b00, 32'h110, 32'h210, 8'd4},
      '{32'h300, 32'h400, 16'd3,  1'b0, 1'b1, 2'b01, 2'b01, 32'h300, 32'h403, 8'd3},
      '{32'h500, 32'h600, 16'd8,  1'b1, 1'b0, 2'b10, 2'b00, 32'h504, 32'h600, 8'd2},
      '{32'h700, 32'h800, 16'd5,  1'b1, 1'b1, 2'b01, 2'b10, 32'h703, 32'h806, 8'd3}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = 3'd0;
   logic [31:0]   reg_wdata = 32'd0;
   logic [31:0]   reg_rdata;
   logic          bus_req, bus_we;
   logic [AW-1:0] bus_addr;
   logic [1:0]    bus_size;
   logic [DW-1:0] bus_wdata, bus_rdata;
   logic          bus_rdy = 1'b1;

   int rdy_ctl = 0;   // 0 always ready, 1 toggling, 2 held low
   int n_chk = 0, n_fail = 0;
   int rd_cnt = 0, wr_cnt = 0, req_cyc = 0;
   logic [31:0] last_waddr = 0, last_wdata = 0;
   logic [1:0]  last_wsize = 0;

   always #10 clk = ~clk;

   dma_xfer_engine dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
   );

   assign bus_rdata = bus_addr ^ SCRAMBLE;

   always begin
      @(posedge clk); #1;
      case (rdy_ctl)
         1:       bus_rdy = ~bus_rdy;
         2:       bus_rdy = 1'b0;
         default: bus_rdy = 1'b1;
      endcase
   end

   always @(negedge clk) begin
      if (bus_req) req_cyc++;
      if (bus_req && bus_rdy && !bus_we) rd_cnt++;
      if (bus_req && bus_rdy && bus_we) begin
         wr_cnt++;
         last_waddr = bus_addr;
         last_wdata = bus_wdata;
         last_wsize = bus_size;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #2;
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(posedge clk); #2;
      reg_addr = a;
      @(negedge clk);
      d = reg_rdata;
   endtask

   task automatic wait_flags();
      logic [31:0] s;
      s = 0;
      for (int i = 0; i < 400 && s == 0; i++) rd(3'd4, s);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   function automatic logic [31:0] nbytes(input logic [1:0] c);
      return (c == 2'b00) ? 32'd4 : (c == 2'b01) ? 32'd1 : (c == 2'b10) ? 32'd2 : 32'd0;
   endfunction

   function automatic logic [31:0] mode_word(input vec_t v);
      return 32'h4000_0000 | (32'(v.dinc) << 12) | (32'(v.dsz) << 8)
           | (32'(v.sinc) << 4) | 32'(v.ssz);
   endfunction

   task automatic run_vec(input vec_t v, input string tag);
      int r0, w0;
      logic [31:0] d, last_src, last_dst;
      wr(3'd4, 32'h3);
      wr(3'd1, v.src);
      wr(3'd2, v.dst);
      wr(3'd3, 32'(v.cnt));
      r0 = rd_cnt; w0 = wr_cnt;
      wr(3'd0, mode_word(v));
      wait_flags();
      last_src = v.sinc ? v.exp_src - nbytes(v.ssz) : v.src;
      last_dst = v.dinc ? v.exp_dst - nbytes(v.dsz) : v.dst;
      chk({tag, " R2 writes"}, 32'(wr_cnt - w0), 32'(v.exp_wr));
      chk({tag, " R2 reads"},  32'(rd_cnt - r0), 32'(v.exp_wr));
      rd(3'd1, d); chk({tag, " R4/R5 src end"}, d, v.exp_src);
      rd(3'd2, d); chk({tag, " R4/R5 dst end"}, d, v.exp_dst);
      rd(3'd3, d); chk({tag, " R6 count zero"}, d, 32'd0);
      rd(3'd4, d); chk({tag, " R6 done flag"}, d, 32'h1);
      rd(3'd0, d); chk({tag, " R6 enable cleared"}, d[30], 1'b0);
      chk({tag, " R2 write data"}, last_wdata, last_src ^ SCRAMBLE);
      chk({tag, " R4/R5 last write addr"}, last_waddr, last_dst);
      chk({tag, " R3 write size"}, 32'(last_wsize), 32'(v.dsz));
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      logic [31:0] d;
      int q0, w0;
      idle(3);
      #2 rst_n = 1'b1;

      // R11 reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), d); chk("R11 reset register", d, 32'd0);
      end
      chk("R11 bus_req idle", 32'(bus_req), 32'd0);

      // R12 reserved bits and layout, EN low
      q0 = req_cyc;
      wr(3'd0, 32'h3FFF_FFFF);
      rd(3'd0, d); chk("R12 mode readback mask", d, 32'h0000_1313);
      idle(6);
      chk("R1 no access with EN low", 32'(req_cyc - q0), 32'd0);

      // R1 programmed but disabled
      wr(3'd0, 32'h0);
      wr(3'd1, 32'h40); wr(3'd3, 32'd12);
      q0 = req_cyc;
      idle(10);
      chk("R1 no bus activity", 32'(req_cyc - q0), 32'd0);
      rd(3'd3, d); chk("R1 count kept", d, 32'd12);
      rd(3'd1, d); chk("R1 src kept", d, 32'h40);

      // table of vectors, zero wait states
      for (int i = 0; i < NV; i++) run_vec(VECS[i], $sformatf("vec%0d", i));

      // R2 with toggling ready
      rdy_ctl = 1;
      run_vec(VECS[0], "stall");
      rdy_ctl = 0;

      // R9 done flag blocks a new start
      wr(3'd1, 32'h1000); wr(3'd2, 32'h2000); wr(3'd3, 32'd8);
      q0 = req_cyc; w0 = wr_cnt;
      wr(3'd0, 32'h4000_1010);
      idle(10);
      chk("R9 done blocks start", 32'(req_cyc - q0), 32'd0);
      rd(3'd3, d); chk("R9 count untouched", d, 32'd8);
      wr(3'd4, 32'h1);
      wait_flags();
      chk("R9 runs after clear", 32'(wr_cnt - w0), 32'd2);
      rd(3'd2, d); chk("R9 dst after run", d, 32'h2008);

      // R8 reserved size
      wr(3'd4, 32'h3); wr(3'd3, 32'd4);
      q0 = req_cyc;
      wr(3'd0, 32'h4000_0003);
      idle(5);
      rd(3'd4, d); chk("R8 error flag", d, 32'h2);
      rd(3'd0, d); chk("R8 enable cleared", d, 32'h0000_0003);
      chk("R8 no access", 32'(req_cyc - q0), 32'd0);
      wr(3'd0, 32'h4000_0000);
      idle(8);
      chk("R9 error blocks start", 32'(req_cyc - q0), 32'd0);
      wr(3'd4, 32'h2);
      wait_flags();
      rd(3'd4, d); chk("R9 error cleared then done", d, 32'h1);

      // R7 zero count
      wr(3'd4, 32'h3); wr(3'd3, 32'd0);
      q0 = req_cyc;
      wr(3'd0, 32'h4000_0000);
      idle(5);
      rd(3'd4, d); chk("R7 done on zero count", d, 32'h1);
      rd(3'd0, d); chk("R7 enable cleared", d, 32'h0);
      chk("R7 no access", 32'(req_cyc - q0), 32'd0);

      // R10 abort during a stalled read
      wr(3'd4, 32'h3);
      wr(3'd1, 32'h900); wr(3'd2, 32'hA00); wr(3'd3, 32'd8);
      rdy_ctl = 2;
      idle(2);
      w0 = wr_cnt;
      wr(3'd0, 32'h4000_1010);
      for (int i = 0; i < 20 && !bus_req; i++) @(negedge clk);
      wr(3'd0, 32'h8000_0000);
      @(negedge clk);
      chk("R10 access held", 32'(bus_req), 32'd1);
      chk("R10 access is read", 32'(bus_we), 32'd0);
      rdy_ctl = 0;
      idle(6);
      @(negedge clk);
      chk("R10 idle after abort", 32'(bus_req), 32'd0);
      chk("R10 no write", 32'(wr_cnt - w0), 32'd0);
      rd(3'd1, d); chk("R10 src unchanged", d, 32'h900);
      rd(3'd2, d); chk("R10 dst unchanged", d, 32'hA00);
      rd(3'd3, d); chk("R10 count unchanged", d, 32'd8);
      rd(3'd0, d); chk("R10 mode reads zero", d, 32'h0);

      finish_up();
   end

endmodule